// File: doc/BRIEF.md
# Timer Compare-Channel Reference Generator

This block is one compare channel of a general-purpose timer. Each clock it compares the timer's count against a compare value and produces a registered, active-high reference level. How the level is formed depends on a 4-bit mode. The modes are hold, set, clear or toggle on a match, force low or high, two PWM senses, and two retriggerable one-pulse forms whose idle level depends on the count direction. A second output merges this channel's reference with a neighbouring channel's reference. It uses OR or AND in the two combined-PWM modes, and passes the plain reference through in every other mode.

The mode field is written through a strobe. With preloading enabled, a write lands in a shadow copy, and a commutation pulse moves the shadow copy into the active mode. While the top lock level is asserted and the channel is an output, writes are dropped. The counter, output polarity, complementary outputs and dead time are handled outside this block.

Top module: `tim_ocref_gen`

## Requirements
- R1: After synchronous reset `oc_ref` is 0, `act_mode` is 0000 (hold) and the one-pulse trigger state is cleared.
- R2: With mode 0000, or with any of the unassigned codes 1010, 1011, 1110 and 1111, `oc_ref` keeps its level whatever the count and compare values are. Every `oc_ref` change appears one clock after the edge at which the inputs were sampled, and the mode used is the one held before that edge.
- R3: Mode 0001 sets `oc_ref` to 1 when count equals compare. Mode 0010 clears it to 0 on a match, and mode 0011 inverts it on each match. Without a match the level is held.
- R4: Mode 0100 drives `oc_ref` to 0 and mode 0101 drives it to 1, independent of the count.
- R5: Modes 0110 and 1100 give `oc_ref` = (count < compare). Modes 0111 and 1101 give `oc_ref` = (count >= compare).
- R6: In mode 1000, when the trigger state is clear, `oc_ref` is 1 while counting up (`cnt_down`=0) and 0 while counting down. When the trigger state is set, `oc_ref` = (count < compare).
- R7: In mode 1001, when the trigger state is clear, `oc_ref` is 0 while counting up and 1 while counting down. When the trigger state is set, `oc_ref` = (count >= compare).
- R8: A `trig_pulse` sets the trigger state and an `upd_pulse` clears it. If both arrive in the same cycle, the trigger wins.
- R9: `oc_ref_comb` is `oc_ref | peer_ref` in mode 1100 and `oc_ref & peer_ref` in mode 1101. In every other mode it equals `oc_ref`.
- R10: With `preload_en`=0, an accepted write puts `mode_wdata` on `act_mode` one clock later.
- R11: With `preload_en`=1, a write changes only the shadow copy, and `act_mode` does not change without a commutation pulse. `com_pulse` copies the shadow into `act_mode` one clock later.
- R12: While `lock_max`=1 and `chan_is_out`=1, mode writes are ignored. A write made while `chan_is_out`=0 is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_val | input | CNT_W | Current timer count |
| cmp_val | input | CNT_W | Compare value |
| cnt_down | input | 1 | 1 when the timer counts down |
| trig_pulse | input | 1 | Trigger event, one cycle |
| upd_pulse | input | 1 | Update event, one cycle |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 4 | Mode value to write |
| preload_en | input | 1 | Route writes to the shadow copy |
| com_pulse | input | 1 | Commutation event, one cycle |
| lock_max | input | 1 | Highest lock level active |
| chan_is_out | input | 1 | Channel configured as output |
| peer_ref | input | 1 | Reference of the neighbouring channel |
| oc_ref | output | 1 | Registered reference level |
| oc_ref_comb | output | 1 | Combined reference |
| act_mode | output | 4 | Active mode |

## Verification
The bench steps through all sixteen mode codes, both count directions and three compare values, including compare 0 and the full-scale value. It does this with a trigger pulse placed mid-sweep and an update pulse at the wrap, and once with both pulses in the same cycle. Three kinds of design error show up here. Taking the comparison one cycle off would put PWM edges in the wrong place. Getting the one-pulse idle level by direction wrong would show up as an inverted idle output. Letting unassigned codes drive the level would make them move it. Directed steps then write modes with preloading on and under lock. A design that bypassed the shadow copy, or ignored the lock, would change `act_mode` in a cycle where the bench expects it held.

// File: rtl/ocref_pkg.sv
// Package: mode codes shared by the compare-channel reference generator.
// Assumes a 4-bit mode field; codes not listed here are unassigned.
package ocref_pkg;
    typedef logic [3:0] ocmode_t;

    localparam ocmode_t M_HOLD  = 4'b0000;
    localparam ocmode_t M_SET   = 4'b0001;
    localparam ocmode_t M_CLR   = 4'b0010;
    localparam ocmode_t M_TGL   = 4'b0011;
    localparam ocmode_t M_LO    = 4'b0100;
    localparam ocmode_t M_HI    = 4'b0101;
    localparam ocmode_t M_PWMA  = 4'b0110;
    localparam ocmode_t M_PWMB  = 4'b0111;
    localparam ocmode_t M_OPA   = 4'b1000;
    localparam ocmode_t M_OPB   = 4'b1001;
    localparam ocmode_t M_CMBA  = 4'b1100;
    localparam ocmode_t M_CMBB  = 4'b1101;
endpackage

// File: rtl/ocref_mode_reg.sv
// Module: holds the shadow and active mode fields.
// Assumes writes and commutation pulses are single-cycle strobes; a
// commutation transfer only applies while preloading is enabled.
module ocref_mode_reg
    import ocref_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr,
    input  ocmode_t wdata,
    input  logic    pre_en,
    input  logic    com,
    input  logic    lock_max,
    input  logic    is_out,
    output ocmode_t act
);
    ocmode_t shadow_q;
    ocmode_t act_q;
    logic    wr_ok;

    // Gate writes by the lock level and the channel direction.
    always_comb wr_ok = wr && !(lock_max && is_out);

    // Update shadow and active fields on writes and commutation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= M_HOLD;
            act_q    <= M_HOLD;
        end else begin
            if (wr_ok)
                shadow_q <= wdata;
            if (pre_en) begin
                if (com)
                    act_q <= shadow_q;
            end else if (wr_ok) begin
                act_q <= wdata;
            end
        end
    end

    assign act = act_q;

    // R12
    lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && lock_max && is_out && !(pre_en && com)) |=> $stable(act_q));

    // R11
    preload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en && !com) |=> $stable(act_q));
endmodule

// File: rtl/ocref_level.sv
// Module: registered reference level and one-pulse trigger state.
// Assumes count and compare are unsigned and sampled on every clock edge.
module ocref_level
    import ocref_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ocmode_t          mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             down,
    input  logic             trig,
    input  logic             upd,
    output logic             ref_o
);
    logic ref_q, ref_d;
    logic trg_q, trg_d;
    logic below, hit;

    // Compute the comparison results and the next reference level.
    always_comb begin
        below = (cnt < cmp);
        hit   = (cnt == cmp);
        ref_d = ref_q;
        case (mode)
            M_SET:          if (hit) ref_d = 1'b1;
            M_CLR:          if (hit) ref_d = 1'b0;
            M_TGL:          if (hit) ref_d = ~ref_q;
            M_LO:           ref_d = 1'b0;
            M_HI:           ref_d = 1'b1;
            M_PWMA, M_CMBA: ref_d = below;
            M_PWMB, M_CMBB: ref_d = ~below;
            M_OPA:          ref_d = trg_q ? below  : ~down;
            M_OPB:          ref_d = trg_q ? ~below : down;
            default:        ref_d = ref_q;
        endcase
    end

    // Trigger state: set by a trigger, cleared by an update, trigger wins.
    always_comb trg_d = trig ? 1'b1 : (upd ? 1'b0 : trg_q);

    // Register the reference level and the trigger state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
            trg_q <= 1'b0;
        end else begin
            ref_q <= ref_d;
            trg_q <= trg_d;
        end
    end

    assign ref_o = ref_q;

    // R2
    hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_HOLD) |=> $stable(ref_q));

    // R4
    force_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_HI) |=> ref_q);

    // R5
    pwm_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == M_PWMA || mode == M_CMBA) && (cnt < cmp)) |=> ref_q);

    // R6
    opa_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_OPA && !trg_q && !down) |=> ref_q);

    // R8
    trig_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && upd) |=> trg_q);
endmodule

// File: rtl/ocref_combine.sv
// Module: merges this channel's reference with a neighbouring one.
// Assumes both references are already registered upstream.
module ocref_combine
    import ocref_pkg::*;
(
    input  ocmode_t mode,
    input  logic    own_ref,
    input  logic    peer_ref,
    output logic    comb
);
    // Pick OR, AND or pass-through by mode.
    always_comb begin
        case (mode)
            M_CMBA:  comb = own_ref | peer_ref;
            M_CMBB:  comb = own_ref & peer_ref;
            default: comb = own_ref;
        endcase
    end
endmodule

// File: rtl/tim_ocref_gen.sv
// Module: top of one timer compare channel's reference generator.
// Assumes the counter, polarity and output stages live elsewhere.
module tim_ocref_gen
    import ocref_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             cnt_down,
    input  logic             trig_pulse,
    input  logic             upd_pulse,
    input  logic             mode_wr,
    input  logic [3:0]       mode_wdata,
    input  logic             preload_en,
    input  logic             com_pulse,
    input  logic             lock_max,
    input  logic             chan_is_out,
    input  logic             peer_ref,
    output logic             oc_ref,
    output logic             oc_ref_comb,
    output logic [3:0]       act_mode
);
    ocmode_t mode_w;
    logic    ref_w;

    ocref_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (mode_wr),
        .wdata    (mode_wdata),
        .pre_en   (preload_en),
        .com      (com_pulse),
        .lock_max (lock_max),
        .is_out   (chan_is_out),
        .act      (mode_w)
    );

    ocref_level #(.CNT_W(CNT_W)) u_level (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode_w),
        .cnt   (cnt_val),
        .cmp   (cmp_val),
        .down  (cnt_down),
        .trig  (trig_pulse),
        .upd   (upd_pulse),
        .ref_o (ref_w)
    );

    ocref_combine u_comb (
        .mode     (mode_w),
        .own_ref  (ref_w),
        .peer_ref (peer_ref),
        .comb     (oc_ref_comb)
    );

    assign oc_ref   = ref_w;
    assign act_mode = mode_w;
endmodule

// File: tb/tim_ocref_gen_tb.sv
module tim_ocref_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt_val = '0, cmp_val = '0;
    logic         cnt_down = 0, trig_pulse = 0, upd_pulse = 0;
    logic         mode_wr = 0, preload_en = 0, com_pulse = 0;
    logic         lock_max = 0, chan_is_out = 0, peer_ref = 0;
    logic [3:0]   mode_wdata = '0;
    logic         oc_ref, oc_ref_comb;
    logic [3:0]   act_mode;

    int  n_chk = 0, n_bad = 0;
    bit  done = 0;

    // reference model state
    logic       m_ref = 0, m_trg = 0;
    logic [3:0] m_act = 0, m_sh = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tim_ocref_gen #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cmp_val(cmp_val),
        .cnt_down(cnt_down), .trig_pulse(trig_pulse), .upd_pulse(upd_pulse),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata), .preload_en(preload_en),
        .com_pulse(com_pulse), .lock_max(lock_max), .chan_is_out(chan_is_out),
        .peer_ref(peer_ref), .oc_ref(oc_ref), .oc_ref_comb(oc_ref_comb),
        .act_mode(act_mode)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(logic [3:0] m);
        case (m)
            4'd0, 4'd10, 4'd11, 4'd14, 4'd15: return "R2";
            4'd1, 4'd2, 4'd3:                 return "R3";
            4'd4, 4'd5:                       return "R4";
            4'd8:                             return "R6";
            4'd9:                             return "R7";
            default:                          return "R5";
        endcase
    endfunction

    // Apply current inputs for one clock, advance model, compare outputs.
    task automatic step(string mtag);
        logic below, hit, nref, ntrg, ok;
        logic [3:0] nact, nsh;
        string rtag;
        below = cnt_val < cmp_val;
        hit   = cnt_val == cmp_val;
        nref  = m_ref;
        case (m_act)
            4'd1: if (hit) nref = 1;
            4'd2: if (hit) nref = 0;
            4'd3: if (hit) nref = ~m_ref;
            4'd4: nref = 0;
            4'd5: nref = 1;
            4'd6, 4'd12: nref = below;
            4'd7, 4'd13: nref = ~below;
            4'd8: nref = m_trg ? below : ~cnt_down;
            4'd9: nref = m_trg ? ~below : cnt_down;
            default: nref = m_ref;
        endcase
        ntrg = trig_pulse ? 1'b1 : (upd_pulse ? 1'b0 : m_trg);
        ok   = mode_wr && !(lock_max && chan_is_out);
        nsh  = ok ? mode_wdata : m_sh;
        nact = m_act;
        if (preload_en) begin
            if (com_pulse) nact = m_sh;
        end else if (ok) nact = mode_wdata;
        rtag = (trig_pulse && upd_pulse) ? "R8" : tag_of(m_act);
        @(posedge clk);
        @(negedge clk);
        m_ref = nref; m_trg = ntrg; m_act = nact; m_sh = nsh;
        chk(rtag, "oc_ref", oc_ref, m_ref);
        chk("R9", "oc_ref_comb", oc_ref_comb,
            (m_act == 4'd12) ? (m_ref | peer_ref) :
            (m_act == 4'd13) ? (m_ref & peer_ref) : m_ref);
        chk(mtag, "act_mode", act_mode, m_act);
    endtask

    task automatic idle();
        mode_wr = 0; trig_pulse = 0; upd_pulse = 0; com_pulse = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "oc_ref", oc_ref, 0);
        chk("R1", "oc_ref_comb", oc_ref_comb, 0);
        chk("R1", "act_mode", act_mode, 0);
        rst_n = 1;
        // R1: trigger cleared -> one-pulse up idles high right after reset
        mode_wr = 1; mode_wdata = 4'd8; step("R10"); idle();
        step("R10");
        chk("R1", "oc_ref opm idle after reset", oc_ref, 1);

        // sweep every mode code, direction and compare value
        for (int m = 0; m < 16; m++) begin
            for (int d = 0; d < 2; d++) begin
                for (int c = 0; c < 3; c++) begin
                    mode_wr = 1; mode_wdata = 4'(m); cnt_down = 1'(d);
                    step("R10"); idle();
                    cmp_val = (c == 0) ? 4'd0 : (c == 1) ? 4'd6 : 4'd15;
                    for (int i = 0; i < 16; i++) begin
                        cnt_val    = d ? 4'(15 - i) : 4'(i);
                        peer_ref   = 1'((i >> 1) & 1);
                        trig_pulse = (i == 3) || (c == 1 && i == 15);
                        upd_pulse  = (i == 15);
                        step("R10");
                    end
                    idle();
                end
            end
        end

        // R11: preload - write held in shadow until commutation
        cnt_val = 4'd2; cmp_val = 4'd9;
        preload_en = 1; mode_wr = 1; mode_wdata = 4'd5; step("R11"); idle();
        step("R11");
        step("R11");
        com_pulse = 1; step("R11"); idle();
        step("R11");
        mode_wr = 1; mode_wdata = 4'd4; step("R11"); idle();
        mode_wr = 1; mode_wdata = 4'd7; com_pulse = 1; step("R11"); idle();
        step("R11");
        preload_en = 0;

        // R12: lock drops writes while output, accepts them otherwise
        lock_max = 1; chan_is_out = 1;
        mode_wr = 1; mode_wdata = 4'd5; step("R12"); idle();
        step("R12");
        chan_is_out = 0;
        mode_wr = 1; mode_wdata = 4'd4; step("R12"); idle();
        step("R12");
        chan_is_out = 1; preload_en = 1;
        mode_wr = 1; mode_wdata = 4'd5; step("R12"); idle();
        com_pulse = 1; step("R12"); idle();
        step("R12");
        lock_max = 0; chan_is_out = 0; preload_en = 0;

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule